// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the word a host reads from a flash-style memory while an internal program or erase operation runs, together with the ready/busy output. An operation engine elsewhere reports which operation is active, whether the current read address falls inside a sector under erase, whether the operation has overrun its time limit and whether the erase command window has closed. The block combines these with two toggle bits, which advance on host read strobes rather than on clock cycles, and drives either a status word or plain array data onto the read path.

Software polls the word. A bit that inverts on each read shows an operation still running. The inverted data bit shows that a program has not finished. A second toggle bit, which runs only for sectors under erase, tells an erase-suspended sector apart from one that can be read normally. A timeout sets a sticky failure bit that holds the status view until a reset command arrives. A hardware reset taken during a busy operation keeps the ready output low for a fixed recovery time.

Top module: `emb_status_gen`

## Requirements
- R1: While rst_n is low, and right after it is released, ryby is 1 and both toggle bits are 0. With op_code idle, rd_data equals arr_data.
- R2: op_code encodes 0 idle, 1 program, 2 erase, 3 erase-suspended read and 4 erase-suspended program. Codes 0 and 5 to 7 show arr_data unchanged on rd_data.
- R3: Status bit 7 is the inverse of prog_d7 in program and suspended-program modes, 0 in erase and 1 for a suspended-read of a sector under erase.
- R4: Status bit 6 shows a toggle register that inverts after each clock edge with rd_stb high while in program, erase or suspended-program mode. Without rd_stb it holds.
- R5: Status bit 2 shows a second toggle register that inverts on rd_stb in erase mode and on reads of a sector under erase in suspended-read mode. Bit 6 holds during suspended reads, and the second toggle register holds during program.
- R6: Status bit 3 equals win_closed in erase mode and is 0 in every other status mode.
- R7: tmo_exceeded in a busy mode sets status bit 5 from the next edge on. The busy mode is then frozen, even if op_code goes idle, until reset_cmd or host_reset. tmo_exceeded while idle has no effect.
- R8: Bits 4, 1, 0 and any bits above 7 read 0 whenever the status word is shown.
- R9: In suspended-read mode, a read with sect_erasing low returns arr_data and advances neither toggle register.
- R10: ryby is 0 in program, erase, suspended-program and failed modes, and 1 in idle and suspended-read modes.
- R11: op_start clears both toggle registers at the next edge, taking priority over a read in that cycle.
- R12: host_reset sampled high in a busy mode keeps ryby at 0 for RST_CYC edges after the last such edge, then releases it. host_reset also clears the toggle registers and the failure. A host_reset taken while idle does not hold ryby low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Active operation, encoded as in R2 |
| op_start | input | 1 | Pulse when a new operation begins |
| rd_stb | input | 1 | Host read strobe, one per read cycle |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| sect_erasing | input | 1 | Read address lies in a sector under erase |
| tmo_exceeded | input | 1 | Operation overran its time limit |
| win_closed | input | 1 | Erase command window has closed |
| reset_cmd | input | 1 | Host reset command, clears a failure |
| host_reset | input | 1 | Synchronous hardware reset request |
| arr_data | input | DW | Array data for the read address |
| rd_data | output | DW | Status word or array data |
| ryby | output | 1 | 1 when ready, 0 when busy |

## Verification
The assertions assume that op_start is pulsed only with a new op_code and that the engine holds op_code steady between changes. They also assume that tmo_exceeded arrives while an operation is busy. The stimulus drives every input at the falling edge, so each read strobe is counted at exactly one rising edge. It changes op_code only together with op_start or a reset, except where a failure freezes the mode on purpose. The expected toggle values are tracked along the whole vector sequence, so each row depends on the reads that came before it.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSP_RD = 3'd3,
    OP_SUSP_PG = 3'd4
  } op_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOGA = 6;
  localparam int BIT_FAIL = 5;
  localparam int BIT_WIN  = 3;
  localparam int BIT_TOGB = 2;

  function automatic logic op_is_busy(input logic [2:0] code);
    return (code == 3'(OP_PROG)) || (code == 3'(OP_ERASE)) || (code == 3'(OP_SUSP_PG));
  endfunction

endpackage

// File: rtl/est_ctrl.sv
module est_ctrl
  import emb_status_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_code,
  input  logic       tmo_exceeded,
  input  logic       reset_cmd,
  input  logic       host_reset,
  output logic [2:0] eff_op,
  output logic       fail,
  output logic       hold
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic          fail_q, fail_d;
  logic [2:0]    fmode_q, fmode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clr_fail;

  assign clr_fail = reset_cmd || host_reset;
  assign eff_op   = fail_q ? fmode_q : op_code;
  assign fail     = fail_q;
  assign hold     = (cnt_q != '0);

  always_comb begin
    fail_d  = fail_q;
    fmode_d = fmode_q;
    if (clr_fail) begin
      fail_d = 1'b0;
    end else if (!fail_q && tmo_exceeded && op_is_busy(op_code)) begin
      fail_d  = 1'b1;
      fmode_d = op_code;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (host_reset && op_is_busy(eff_op)) begin
      cnt_d = CW'(RST_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      fmode_q <= 3'(OP_IDLE);
      cnt_q   <= '0;
    end else begin
      fail_q  <= fail_d;
      fmode_q <= fmode_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !reset_cmd && !host_reset) |=> fail_q); // R7
  AST_FAIL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_exceeded && op_is_busy(op_code) && !reset_cmd && !host_reset) |=> fail_q); // R7
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !host_reset) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R12

endmodule

// File: rtl/est_toggle.sv
module est_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_stb,
  input  logic en_a,
  input  logic en_b,
  output logic tog_a,
  output logic tog_b
);
  logic a_q, a_d, b_q, b_d;

  assign tog_a = a_q;
  assign tog_b = b_q;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (clr) begin
      a_d = 1'b0;
      b_d = 1'b0;
    end else if (rd_stb) begin
      if (en_a) a_d = ~a_q;
      if (en_b) b_d = ~b_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  AST_TOGA_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && en_a && !clr) |=> (tog_a != $past(tog_a))); // R4
  AST_TOGB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && en_b && !clr) |=> (tog_b != $past(tog_b))); // R5
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !clr) |=> ($stable(tog_a) && $stable(tog_b))); // R4
  AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tog_a && !tog_b)); // R11

endmodule

// File: rtl/est_word.sv
module est_word
  import emb_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    eff_op,
  input  logic          fail,
  input  logic          prog_d7,
  input  logic          sect_erasing,
  input  logic          win_closed,
  input  logic          tog_a,
  input  logic          tog_b,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          stat_rd,
  output logic          en_a,
  output logic          en_b
);
  logic          is_prog, is_erase, susp_hit;
  logic [DW-1:0] word;

  assign is_prog  = (eff_op == 3'(OP_PROG)) || (eff_op == 3'(OP_SUSP_PG));
  assign is_erase = (eff_op == 3'(OP_ERASE));
  assign susp_hit = (eff_op == 3'(OP_SUSP_RD)) && sect_erasing;
  assign stat_rd  = op_is_busy(eff_op) || susp_hit;
  assign en_a     = op_is_busy(eff_op);
  assign en_b     = is_erase || susp_hit;

  always_comb begin
    word           = '0;
    word[BIT_POLL] = is_prog ? ~prog_d7 : susp_hit;
    word[BIT_TOGA] = tog_a;
    word[BIT_FAIL] = fail;
    word[BIT_WIN]  = is_erase && win_closed;
    word[BIT_TOGB] = (is_erase || susp_hit) && tog_b;
    rd_data        = stat_rd ? word : arr_data;
  end

endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
  import emb_status_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RST_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_code,
  input  logic          op_start,
  input  logic          rd_stb,
  input  logic          prog_d7,
  input  logic          sect_erasing,
  input  logic          tmo_exceeded,
  input  logic          win_closed,
  input  logic          reset_cmd,
  input  logic          host_reset,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          ryby
);
  logic [2:0] eff_op;
  logic       fail, hold, stat_rd, en_a, en_b, tog_a, tog_b;

  est_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
    .clk, .rst_n, .op_code, .tmo_exceeded, .reset_cmd, .host_reset,
    .eff_op, .fail, .hold
  );

  est_toggle u_tog (
    .clk, .rst_n, .clr(op_start || host_reset), .rd_stb,
    .en_a, .en_b, .tog_a, .tog_b
  );

  est_word #(.DW(DW)) u_word (
    .eff_op, .fail, .prog_d7, .sect_erasing, .win_closed,
    .tog_a, .tog_b, .arr_data, .rd_data, .stat_rd, .en_a, .en_b
  );

  assign ryby = !op_is_busy(eff_op) && !hold;

  AST_RYBY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_busy(op_code) |-> !ryby); // R10
  AST_ARRAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail && !op_is_busy(op_code) && op_code != 3'(OP_SUSP_RD)) |-> (rd_data == arr_data)); // R2
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_reset && op_is_busy(op_code)) |=> !ryby); // R12
  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00)); // R8

endmodule

// File: tb/emb_status_gen_bench.sv
module emb_status_gen_bench;
  localparam int DW = 8;
  localparam int RC = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    op_code;
  logic          op_start, rd_stb, prog_d7, sect_erasing;
  logic          tmo_exceeded, win_closed, reset_cmd, host_reset;
  logic [DW-1:0] arr_data, rd_data;
  logic          ryby;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  emb_status_gen #(.DW(DW), .RST_CYC(RC)) u_emb_status_gen (
    .clk, .rst_n, .op_code, .op_start, .rd_stb, .prog_d7, .sect_erasing,
    .tmo_exceeded, .win_closed, .reset_cmd, .host_reset, .arr_data,
    .rd_data, .ryby
  );

  typedef struct packed {
    logic [2:0] op;
    logic       st, rd, d7, sect, win;
    logic [7:0] arr, exp;
    logic       rb;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VT [20] = '{
    '{3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1,4'd2},  // R2 idle
    '{3'd1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h5A,8'h00,1'b0,4'd3},  // R3 program start
    '{3'd1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h5A,8'h00,1'b0,4'd4},  // R4
    '{3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,8'hC0,1'b0,4'd3},  // R3
    '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h80,1'b0,4'd4},  // R4
    '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h80,1'b0,4'd5},  // R5
    '{3'd2,1'b1,1'b1,1'b0,1'b0,1'b0,8'h5A,8'h00,1'b0,4'd11}, // R11 start wins
    '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b1,8'h5A,8'h08,1'b0,4'd6},  // R6
    '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b1,8'h5A,8'h4C,1'b0,4'd5},  // R5
    '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,8'h00,1'b0,4'd6},  // R6
    '{3'd3,1'b0,1'b1,1'b0,1'b1,1'b0,8'h5A,8'hC4,1'b1,4'd10}, // R10
    '{3'd3,1'b0,1'b1,1'b0,1'b1,1'b0,8'h5A,8'hC0,1'b1,4'd5},  // R5
    '{3'd3,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1,4'd9},  // R9
    '{3'd3,1'b0,1'b0,1'b0,1'b1,1'b0,8'h5A,8'hC4,1'b1,4'd5},  // R5
    '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,8'hC0,1'b0,4'd10}, // R10
    '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,8'h5A,8'h00,1'b0,4'd4},  // R4
    '{3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1,4'd2},  // R2
    '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,8'h5A,8'h5A,1'b1,4'd2},  // R2
    '{3'd1,1'b1,1'b0,1'b1,1'b0,1'b0,8'hA5,8'h40,1'b0,4'd11}, // R11
    '{3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,8'hA5,8'h00,1'b0,4'd11}  // R11
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_code = 3'd0; op_start = 0; rd_stb = 0; prog_d7 = 0; sect_erasing = 0;
    tmo_exceeded = 0; win_closed = 0; reset_cmd = 0; host_reset = 0; arr_data = 8'h3C;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 data in reset", rd_data, 8'h3C);
    chk("R1 ryby in reset", {7'd0, ryby}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    op_code = 3'd1; prog_d7 = 0;
    #1;
    chk("R1 toggles zero after reset", rd_data, 8'h80);

    @(negedge clk);
    foreach (VT[i]) begin
      op_code = VT[i].op; op_start = VT[i].st; rd_stb = VT[i].rd;
      prog_d7 = VT[i].d7; sect_erasing = VT[i].sect; win_closed = VT[i].win;
      arr_data = VT[i].arr;
      #1;
      chk($sformatf("R%0d vec %0d data", VT[i].req, i), rd_data, VT[i].exp);
      chk($sformatf("R%0d vec %0d ryby", VT[i].req, i), {7'd0, ryby}, {7'd0, VT[i].rb});
      @(negedge clk);
    end

    // R8: unused bits zero in an erase status with everything set
    idle_inputs();
    op_code = 3'd2; op_start = 1; win_closed = 1; arr_data = 8'hFF;
    @(negedge clk);
    op_start = 0; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    #1;
    chk("R8 unused bits", rd_data & 8'h13, 8'h00);

    // R7: timeout while idle has no effect
    idle_inputs();
    tmo_exceeded = 1;
    @(negedge clk);
    tmo_exceeded = 0;
    #1;
    chk("R7 idle timeout ignored", rd_data, 8'h3C);

    // R7: timeout during program freezes the mode
    op_code = 3'd1; op_start = 1; prog_d7 = 1;
    @(negedge clk);
    op_start = 0; tmo_exceeded = 1;
    @(negedge clk);
    tmo_exceeded = 0; op_code = 3'd0;
    #1;
    chk("R7 fail bit, frozen program", rd_data, 8'h20);
    chk("R10 ryby low when failed", {7'd0, ryby}, 8'h00);
    @(negedge clk);
    #1;
    chk("R7 fail persists", rd_data, 8'h20);
    reset_cmd = 1;
    @(negedge clk);
    reset_cmd = 0;
    #1;
    chk("R7 reset command clears", rd_data, 8'h3C);
    chk("R7 ryby after clear", {7'd0, ryby}, 8'h01);

    // R12: hardware reset during erase holds ryby low for RC edges
    op_code = 3'd2; op_start = 1;
    @(negedge clk);
    op_start = 0; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; host_reset = 1;
    @(negedge clk);
    host_reset = 0; op_code = 3'd0;
    #1;
    chk("R12 ryby low after reset", {7'd0, ryby}, 8'h00);
    repeat (RC - 1) @(negedge clk);
    #1;
    chk("R12 ryby still low at last hold edge", {7'd0, ryby}, 8'h00);
    @(negedge clk);
    #1;
    chk("R12 ryby released", {7'd0, ryby}, 8'h01);
    op_code = 3'd1; prog_d7 = 1;
    #1;
    chk("R12 reset cleared toggles", rd_data, 8'h00);

    // R12: hardware reset while idle gives no hold
    op_code = 3'd0; host_reset = 1;
    @(negedge clk);
    host_reset = 0;
    #1;
    chk("R12 idle reset no hold", {7'd0, ryby}, 8'h01);

    finish_run();
  end
endmodule